// File: doc/BRIEF.md
# Condition-Code Flag Unit

This block derives the negative, zero, overflow and carry flags for an 8/16-bit accumulator processor and holds them in an 8-bit condition-code register. The datapath supplies the two operands, the result it produced, an operation class and a width select. The unit rebuilds carry and overflow from the sign bits of the operands and the result only, so it needs no access to the adder's internal carry chain. On an update strobe the four arithmetic flags are merged into the register. The four control bits (stop-disable, extended-interrupt mask, half-carry, interrupt mask) are left alone by an update and change only through a direct byte write.

The operation class selects the flag rule. Add and subtract use majority-style carry/borrow and sign-agreement overflow. A test clears overflow and keeps carry. A shift takes its carry from the shifter and sets overflow to N XOR C. The width select picks bit 7 or bit 15 as the sign bit and narrows the zero detect to match.

Top module: `cc_flag_unit`

## Requirements
- R1: While reset is low and in the first cycle after it, cc_o reads 0xD0. The register layout is bit7 S, bit6 X, bit5 H, bit4 I, bit3 N, bit2 Z, bit1 V, bit0 C.
- R2: For op_i=2'b00 (add), one cycle after an update C is set when at least two of {a sign, b sign, NOT r sign} are 1, and V is set when a and b have the same sign and r's sign differs.
- R3: For op_i=2'b01 (subtract), C is set when at least two of {NOT a sign, b sign, r sign} are 1, and V is set when a and b differ in sign and r's sign differs from a's.
- R4: For every class, N takes r's sign bit and Z is set exactly when r is zero over the selected width.
- R5: For op_i=2'b10 (test), V is cleared and C keeps its previous value.
- R6: For op_i=2'b11 (shift), C takes shift_c_i and V becomes the new N XOR shift_c_i.
- R7: With wide_i=0 the sign bit is bit 7, and bits 15:8 of a_i, b_i and r_i have no effect on any flag. With wide_i=1 the sign bit is bit 15.
- R8: A flag update leaves bits 7:4 (S, X, H, I) unchanged.
- R9: wr_i loads wr_data_i into all eight bits on the next clock edge and takes precedence over a simultaneous upd_i.
- R10: With upd_i and wr_i both low, cc_o holds its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Merge the computed flags into the register |
| op_i | input | 2 | Operation class: 00 add, 01 subtract, 10 test, 11 shift |
| wide_i | input | 1 | 1 selects 16-bit width, 0 selects 8-bit |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| r_i | input | 16 | Result from the datapath |
| shift_c_i | input | 1 | Carry out of the shifter |
| wr_i | input | 1 | Direct write of the whole register |
| wr_data_i | input | 8 | Byte for the direct write |
| cc_o | output | 8 | Condition-code register |

## Verification
The carry assertions can only fire when r_i really is the sum or difference of the operands, because that is the only case in which the sign-bit rule matches the true carry or borrow. Their antecedents therefore require that agreement. The test, shift, zero and hold assertions make no assumption about how r_i relates to the operands. The random stimulus makes r_i the true result of the chosen operation about two times in three and an unrelated value otherwise, so the carry assertions see enough cases while the other rules are also exercised on arbitrary results.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_TST = 2'b10,
    OP_SHF = 2'b11
  } cc_op_e;

  localparam int CC_W  = 8;
  localparam int BIT_S = 7;
  localparam int BIT_X = 6;
  localparam int BIT_H = 5;
  localparam int BIT_I = 4;
  localparam int BIT_N = 3;
  localparam int BIT_Z = 2;
  localparam int BIT_V = 1;
  localparam int BIT_C = 0;
  localparam logic [CC_W-1:0] CC_RST = 8'hD0;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_flags_t;
endpackage

// File: rtl/cc_lane_sel.sv
module cc_lane_sel #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              wide_i,
  input  logic [2:0]        sign_w_i,  // {a,b,r} sign at full width
  input  logic [2:0]        sign_n_i,  // {a,b,r} sign at narrow width
  input  logic [DATA_W-1:0] r_i,
  output logic              a_s_o,
  output logic              b_s_o,
  output logic              r_s_o,
  output logic              r_z_o
);
  logic [2:0] sign_sel;
  logic       zero_w, zero_n;

  assign zero_w = ~|r_i;

  generate
    if (NARROW_W < DATA_W) begin : g_dual
      assign zero_n   = ~|r_i[NARROW_W-1:0];
      assign sign_sel = wide_i ? sign_w_i : sign_n_i;
      assign r_z_o    = wide_i ? zero_w : zero_n;
    end else begin : g_single
      assign zero_n   = zero_w;
      assign sign_sel = sign_w_i;
      assign r_z_o    = zero_w;
    end
  endgenerate

  assign {a_s_o, b_s_o, r_s_o} = sign_sel;
endmodule

// File: rtl/cc_flag_calc.sv
module cc_flag_calc
  import cc_pkg::*;
(
  input  cc_op_e    op_i,
  input  logic      a_s_i,
  input  logic      b_s_i,
  input  logic      r_s_i,
  input  logic      r_z_i,
  input  logic      shift_c_i,
  input  logic      old_c_i,
  output cc_flags_t flags_o
);
  always_comb begin
    flags_o.n = r_s_i;
    flags_o.z = r_z_i;
    flags_o.v = 1'b0;
    flags_o.c = old_c_i;
    unique case (op_i)
      OP_ADD: begin
        flags_o.c = (a_s_i & b_s_i) | (b_s_i & ~r_s_i) | (a_s_i & ~r_s_i);
        flags_o.v = (a_s_i & b_s_i & ~r_s_i) | (~a_s_i & ~b_s_i & r_s_i);
      end
      OP_SUB: begin
        flags_o.c = (~a_s_i & b_s_i) | (b_s_i & r_s_i) | (~a_s_i & r_s_i);
        flags_o.v = (a_s_i & ~b_s_i & ~r_s_i) | (~a_s_i & b_s_i & r_s_i);
      end
      OP_TST: begin
        flags_o.v = 1'b0;
        flags_o.c = old_c_i;
      end
      OP_SHF: begin
        flags_o.c = shift_c_i;
        flags_o.v = r_s_i ^ shift_c_i;  // new N xor new C
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cc_reg.sv
module cc_reg
  import cc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            upd_i,
  input  cc_op_e          op_i,
  input  cc_flags_t       flags_i,
  input  logic            wr_i,
  input  logic [CC_W-1:0] wr_data_i,
  output logic [CC_W-1:0] cc_o
);
  logic [CC_W-1:0] cc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_q <= CC_RST;
    end else if (wr_i) begin
      cc_q <= wr_data_i;
    end else if (upd_i) begin
      cc_q[BIT_N] <= flags_i.n;
      cc_q[BIT_Z] <= flags_i.z;
      cc_q[BIT_V] <= flags_i.v;
      cc_q[BIT_C] <= flags_i.c;
    end
  end

  assign cc_o = cc_q;

  assert_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cc_o == $past(wr_data_i));

  assert_ctrl_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> cc_o[BIT_S:BIT_I] == $past(cc_o[BIT_S:BIT_I]));

  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !upd_i) |=> $stable(cc_o));

  assert_test_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !wr_i && op_i == OP_TST) |=>
      (!cc_o[BIT_V] && cc_o[BIT_C] == $past(cc_o[BIT_C])));

  assert_shift_v_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !wr_i && op_i == OP_SHF) |=> cc_o[BIT_V] == (cc_o[BIT_N] ^ cc_o[BIT_C]));
endmodule

// File: rtl/cc_flag_unit.sv
module cc_flag_unit
  import cc_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [1:0]        op_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] r_i,
  input  logic              shift_c_i,
  input  logic              wr_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        cc_o
);
  localparam int MSB_W = DATA_W - 1;
  localparam int MSB_N = NARROW_W - 1;

  cc_op_e    op;
  logic      a_s, b_s, r_s, r_z;
  cc_flags_t flags;

  assign op = cc_op_e'(op_i);

  cc_lane_sel #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_lane (
    .wide_i   (wide_i),
    .sign_w_i ({a_i[MSB_W], b_i[MSB_W], r_i[MSB_W]}),
    .sign_n_i ({a_i[MSB_N], b_i[MSB_N], r_i[MSB_N]}),
    .r_i      (r_i),
    .a_s_o    (a_s),
    .b_s_o    (b_s),
    .r_s_o    (r_s),
    .r_z_o    (r_z)
  );

  cc_flag_calc u_calc (
    .op_i      (op),
    .a_s_i     (a_s),
    .b_s_i     (b_s),
    .r_s_i     (r_s),
    .r_z_i     (r_z),
    .shift_c_i (shift_c_i),
    .old_c_i   (cc_o[BIT_C]),
    .flags_o   (flags)
  );

  cc_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (upd_i),
    .op_i      (op),
    .flags_i   (flags),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .cc_o      (cc_o)
  );

  // True full-width carry/borrow, only for cross-checking the sign-bit rule
  logic [DATA_W:0] add_chk, sub_chk;
  assign add_chk = {1'b0, a_i} + {1'b0, b_i};
  assign sub_chk = {1'b0, a_i} - {1'b0, b_i};

  assert_add_carry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !wr_i && wide_i && op == OP_ADD && r_i == add_chk[DATA_W-1:0]) |=>
      cc_o[BIT_C] == $past(add_chk[DATA_W]));

  assert_sub_borrow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !wr_i && wide_i && op == OP_SUB && r_i == sub_chk[DATA_W-1:0]) |=>
      cc_o[BIT_C] == $past(sub_chk[DATA_W]));

  assert_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !wr_i) |=>
      cc_o[BIT_Z] == ($past(wide_i) ? ($past(r_i) == '0)
                                    : ($past(r_i[MSB_N:0]) == '0)));

  assert_shift_carry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !wr_i && op == OP_SHF) |=> cc_o[BIT_C] == $past(shift_c_i));
endmodule

// File: tb/tb_cc_flag_unit.sv
module tb_cc_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd, wide, sc, wr;
  logic [1:0]  op;
  logic [15:0] a, b, r;
  logic [7:0]  wd;
  logic [7:0]  cc_o;
  logic [7:0]  model;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  cc_flag_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .upd_i(upd), .op_i(op), .wide_i(wide),
    .a_i(a), .b_i(b), .r_i(r), .shift_c_i(sc), .wr_i(wr), .wr_data_i(wd),
    .cc_o(cc_o)
  );

  function automatic logic [7:0] expect_cc(input logic [7:0] old, input logic [1:0] o,
                                           input logic w, input logic [15:0] ea, eb, er,
                                           input logic esc);
    logic as, bs, rs, zz, c, v;
    as = w ? ea[15] : ea[7];
    bs = w ? eb[15] : eb[7];
    rs = w ? er[15] : er[7];
    zz = w ? (er == 16'h0) : (er[7:0] == 8'h00);
    c  = old[0];
    v  = 1'b0;
    case (o)
      2'b00: begin
        c = (int'(as) + int'(bs) + int'(!rs)) >= 2;
        v = (as == bs) && (rs != as);
      end
      2'b01: begin
        c = (int'(!as) + int'(bs) + int'(rs)) >= 2;
        v = (as != bs) && (rs != as);
      end
      2'b10: begin
        v = 1'b0;
        c = old[0];
      end
      default: begin
        c = esc;
        v = rs ^ esc;
      end
    endcase
    return {old[7:4], rs, zz, v, c};
  endfunction

  task automatic check(input string tag, input logic [7:0] exp);
    n_chk++;
    if (cc_o !== exp) begin
      n_bad++;
      $display("FAIL %s: cc_o=%02h expected %02h", tag, cc_o, exp);
    end
  endtask

  task automatic apply(input logic u, input logic w, input logic [7:0] d,
                       input logic [1:0] o, input logic ws,
                       input logic [15:0] ea, eb, er, input logic esc,
                       input string tag);
    @(negedge clk);
    upd = u; wr = w; wd = d; op = o; wide = ws; a = ea; b = eb; r = er; sc = esc;
    @(posedge clk);
    #1;
    if (w) model = d;
    else if (u) model = expect_cc(model, o, ws, ea, eb, er, esc);
    check(tag, model);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: cc_o=%02h expected completion", cc_o);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed_c0de);
    rst_n = 1'b0; upd = 0; wr = 0; wd = 0; op = 0; wide = 0; a = 0; b = 0; r = 0; sc = 0;
    model = 8'hD0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", 8'hD0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 8'hD0);

    // R2 add corners, narrow and wide
    apply(1, 0, 0, 2'b00, 0, 16'h007F, 16'h0001, 16'h0080, 0, "R2 add 7F+01");
    check("R2 add overflow 0xDA", 8'hDA);
    apply(1, 0, 0, 2'b00, 0, 16'h00FF, 16'h0001, 16'h0000, 0, "R2 add FF+01");
    check("R4 add zero with carry 0xD5", 8'hD5);
    apply(1, 0, 0, 2'b00, 1, 16'hFFFF, 16'h0001, 16'h0000, 0, "R2 wide add");
    apply(1, 0, 0, 2'b00, 1, 16'h7FFF, 16'h0001, 16'h8000, 0, "R2 wide overflow");
    // R3 subtract corners
    apply(1, 0, 0, 2'b01, 0, 16'h0000, 16'h0001, 16'h00FF, 0, "R3 sub 00-01");
    check("R3 borrow 0xD9", 8'hD9);
    apply(1, 0, 0, 2'b01, 0, 16'h0080, 16'h0001, 16'h007F, 0, "R3 sub 80-01");
    check("R3 overflow 0xD2", 8'hD2);
    apply(1, 0, 0, 2'b01, 1, 16'h8000, 16'h8000, 16'h0000, 0, "R3 wide equal");
    // R5 test keeps C, clears V
    apply(1, 0, 0, 2'b01, 0, 16'h0000, 16'h0001, 16'h00FF, 0, "R3 set C");
    apply(1, 0, 0, 2'b10, 0, 16'h0000, 16'h0000, 16'h0000, 0, "R5 test zero");
    check("R5 test keeps C 0xD5", 8'hD5);
    apply(1, 0, 0, 2'b10, 1, 16'h0000, 16'h0000, 16'h8001, 0, "R5 test neg");
    // R6 shift
    apply(1, 0, 0, 2'b11, 0, 16'h0000, 16'h0000, 16'h0080, 1, "R6 shift N1 C1");
    check("R6 V=N^C 0xD9", 8'hD9);
    apply(1, 0, 0, 2'b11, 0, 16'h0000, 16'h0000, 16'h0000, 1, "R6 shift Z C1");
    check("R6 V=N^C 0xD7", 8'hD7);
    // R7 narrow ignores high bytes
    apply(1, 0, 0, 2'b00, 0, 16'hAB7F, 16'hCD01, 16'h1280, 0, "R7 narrow high bytes");
    check("R7 same as clean 7F+01", 8'hDA);
    apply(1, 0, 0, 2'b10, 0, 16'h0000, 16'h0000, 16'hFF00, 0, "R7 narrow zero");
    // R8 control bits survive updates
    apply(0, 1, 8'h2F, 2'b00, 0, 0, 0, 0, 0, "R9 write 2F");
    apply(1, 0, 0, 2'b00, 1, 16'h0001, 16'h0001, 16'h0002, 0, "R8 update after write");
    check("R8 upper nibble 0x20", 8'h20);
    // R9 write beats update
    apply(1, 1, 8'hA5, 2'b11, 1, 16'h0000, 16'h0000, 16'h8000, 0, "R9 write over update");
    // R10 idle holds
    apply(0, 0, 8'h00, 2'b01, 1, 16'h1234, 16'h5678, 16'h0000, 1, "R10 idle");
    check("R10 held 0xA5", 8'hA5);

    for (int i = 0; i < 3000; i++) begin
      logic [1:0]  ro;
      logic        rw, ru, rwr;
      logic [15:0] ra, rb, rr;
      string       tag;
      ro  = 2'($urandom);
      rw  = 1'($urandom);
      ra  = 16'($urandom);
      rb  = 16'($urandom);
      ru  = ($urandom % 8) != 0;
      rwr = ($urandom % 16) == 0;
      if (($urandom % 3) == 0) rr = 16'($urandom);
      else if (ro == 2'b01) rr = ra - rb;
      else if (ro == 2'b00) rr = ra + rb;
      else rr = ra << 1;
      if (($urandom % 8) == 0) rr = rw ? 16'h0000 : {rr[15:8], 8'h00};
      case (ro)
        2'b00:   tag = rw ? "R2 rand add" : "R7 R2 rand add";
        2'b01:   tag = rw ? "R3 rand sub" : "R7 R3 rand sub";
        2'b10:   tag = "R5 R4 rand test";
        default: tag = "R6 R4 rand shift";
      endcase
      if (rwr) tag = "R9 rand write";
      else if (!ru) tag = "R10 rand idle";
      apply(ru, rwr, 8'($urandom), ro, rw, ra, rb, rr, 1'($urandom), tag);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule